// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencer

This controller decides when the working SRAM array is copied into its shadow nonvolatile copy (a STORE) and when that copy is loaded back (a RECALL). A STORE can be requested in three ways: by software, by another device pulling the shared open-drain handshake line low, or automatically when the supply drops below its threshold. A RECALL can be requested by software, and one is always queued when the supply is low or the block has just been powered up. Every phase runs for a fixed number of clock cycles. While a phase runs, the controller holds the handshake line low and blocks the host's SRAM reads and writes.

A dirty flag records whether any write has been accepted since the last completed transfer. Automatic and line-requested stores are skipped while this flag is clear. Software stores run whether or not the flag is set. A store first opens a short grace window, in which a write that was already being accepted may finish. After a store completes, the line is actively driven high for a few cycles and then released. Access stays blocked for as long as some other agent keeps holding the line low.

The automatic-store enable flag is changed by software commands. A manual store (software or line-requested) saves its current value, and every completed RECALL reloads the flag from that saved copy. Reset leaves both the flag and its saved copy enabled. The array's data path is outside this block: it produces one-cycle strobes that commit the array, clear it, and load it.

Top module: `nvseq_ctrl`

## Requirements
- R1: While reset is held, `busy`, `line_pull_low`, `line_push_high`, `dirty`, `rd_en` and `wr_en` are 0 and `autostore_en` is 1. A RECALL is queued from reset.
- R2: A RECALL lasts RECALL_CYC cycles and drives `line_pull_low` throughout. `sram_clear` pulses in its first cycle. `sram_load` and `done` pulse in its last cycle. The nonvolatile copy is left unchanged.
- R3: A software store command taken in idle cycle k always runs, even with `dirty` clear. The grace window covers cycles k+1..k+GRACE_CYC. `nv_commit` and `done` pulse in cycle k+GRACE_CYC+STORE_CYC.
- R4: A high-to-low transition of `line_in` (1 = line high) seen in idle cycle k while `dirty` is 1 starts a store with the same timing as R3. `line_pull_low` is 1 from cycle k+1 to the commit cycle.
- R5: A high-to-low transition of `line_in` while `dirty` is 0 starts no store and does not drive the line. Whenever `line_in` is 0 in idle, `rd_en` and `wr_en` stay 0. They follow the requests again once the line is high.
- R6: A rise of `supply_low` in idle starts a store (timing as R3) only when `autostore_en` and `dirty` are both 1. Otherwise no store runs.
- R7: During the grace window, `wr_en` stays 1 only for a write that was accepted in the previous cycle and is still requested. A write requested after the window opens is refused.
- R8: `rd_en` and `wr_en` are 0 during any store or RECALL phase, during the drive-high phase, and while `supply_low` is 1. The grace continuation of R7 is the only exception.
- R9: After each commit, `line_push_high` is 1 for PUSH_CYC cycles and `line_pull_low` is 0 during that time. The block then returns to idle with both line outputs 0.
- R10: `dirty` becomes 1 after any accepted write. It becomes 0 in the cycle after each commit or RECALL load.
- R11: The enable command sets `autostore_en` to 1 and the disable command sets it to 0. A completed manual store saves the flag. An automatic store does not save it. Each completed RECALL reloads the saved value into `autostore_en`.
- R12: A RECALL is queued whenever `supply_low` is 1. It starts in the cycle after `supply_low` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| supply_low | input | 1 | Supply is below the switch threshold |
| line_in | input | 1 | Sensed level of the shared open-drain handshake line |
| sw_store | input | 1 | Decoded software STORE command, one cycle |
| sw_recall | input | 1 | Decoded software RECALL command, one cycle |
| sw_as_enable | input | 1 | Decoded command enabling automatic store |
| sw_as_disable | input | 1 | Decoded command disabling automatic store |
| rd_req | input | 1 | Host SRAM read request |
| wr_req | input | 1 | Host SRAM write request |
| rd_en | output | 1 | Gated SRAM read enable |
| wr_en | output | 1 | Gated SRAM write enable |
| line_pull_low | output | 1 | Open-drain pull-down of the handshake line |
| line_push_high | output | 1 | Short active drive of the line high after a store |
| busy | output | 1 | A transfer phase is running |
| done | output | 1 | One-cycle pulse at the end of a STORE or RECALL |
| nv_commit | output | 1 | Copy the SRAM array into the nonvolatile copy |
| sram_clear | output | 1 | Clear the SRAM array (first RECALL cycle) |
| sram_load | output | 1 | Load the SRAM array from the nonvolatile copy |
| dirty | output | 1 | A write has been accepted since the last transfer |
| autostore_en | output | 1 | Automatic store on supply loss is enabled |

## Verification
Each trigger is raised in a known cycle k. The results follow from that cycle: a commit is due at k+GRACE_CYC+STORE_CYC, a RECALL's clear at k+1 and its load at k+RECALL_CYC. The drive-high window covers the PUSH_CYC cycles after the commit, and the block is idle again one cycle later. The driver pushes each expected strobe into a queue together with its due cycle. A monitor compares every strobe the block raises against the head of that queue, on the falling edge of the cycle it appears in, so an early, late, missing or extra transfer is reported. Gating and flag checks are sampled on falling edges after the inputs have settled. Their expected values come from the requirement timing.

// File: rtl/nvseq_pkg.sv
package nvseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GRACE,
    ST_STORE,
    ST_PUSH,
    ST_RECALL
  } nv_state_e;

  typedef enum logic [1:0] {
    SRC_SW,
    SRC_PIN,
    SRC_AUTO
  } nv_src_e;

endpackage

// File: rtl/nvseq_timer.sv
module nvseq_timer #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count,
  output logic         zero
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;
  assign zero  = (cnt_q == '0);

  // The counter only moves down by one or reloads; it never wraps from zero.
  AST_TIMER_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_ni)
    ($past(cnt_q) == '0 && !$past(load)) |-> cnt_q == '0) else $error("timer wrapped"); // R2

endmodule

// File: rtl/nvseq_flags.sv
module nvseq_flags (
  input  logic clk,
  input  logic rst_ni,
  input  logic vlow,
  input  logic wr_acc,
  input  logic cmd_ok,
  input  logic as_set_cmd,
  input  logic as_clr_cmd,
  input  logic commit,
  input  logic manual,
  input  logic load,
  output logic dirty,
  output logic as_en,
  output logic recall_pend,
  output logic vlow_q
);

  logic dirty_q, dirty_d;
  logic as_en_q, as_en_d;
  logic as_saved_q, as_saved_d;
  logic pend_q, pend_d;
  logic vlow_d;

  always_comb begin
    dirty_d = dirty_q;
    if (commit || load) begin
      dirty_d = 1'b0;
    end else if (wr_acc) begin
      dirty_d = 1'b1;
    end
  end

  always_comb begin
    as_en_d = as_en_q;
    if (load) begin
      as_en_d = as_saved_q;
    end else if (cmd_ok && as_set_cmd) begin
      as_en_d = 1'b1;
    end else if (cmd_ok && as_clr_cmd) begin
      as_en_d = 1'b0;
    end
  end

  always_comb begin
    as_saved_d = as_saved_q;
    if (commit && manual) begin
      as_saved_d = as_en_q;
    end
  end

  always_comb begin
    pend_d = pend_q;
    if (vlow) begin
      pend_d = 1'b1;
    end else if (load) begin
      pend_d = 1'b0;
    end
  end

  assign vlow_d = vlow;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      dirty_q    <= 1'b0;
      as_en_q    <= 1'b1;
      as_saved_q <= 1'b1;
      pend_q     <= 1'b1;
      vlow_q     <= 1'b1;
    end else begin
      dirty_q    <= dirty_d;
      as_en_q    <= as_en_d;
      as_saved_q <= as_saved_d;
      pend_q     <= pend_d;
      vlow_q     <= vlow_d;
    end
  end

  assign dirty       = dirty_q;
  assign as_en       = as_en_q;
  assign recall_pend = pend_q;

  AST_DIRTY_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(dirty_q) |-> $past(wr_acc)) else $error("dirty set without write"); // R10

  AST_SAVED_ONLY_MANUAL: assert property (@(posedge clk) disable iff (!rst_ni)
    !$stable(as_saved_q) |-> $past(commit && manual)) else $error("saved flag changed"); // R11

  AST_PEND_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_ni)
    $past(vlow) |-> pend_q) else $error("recall not queued"); // R12

endmodule

// File: rtl/nvseq_fsm.sv
module nvseq_fsm
  import nvseq_pkg::*;
#(
  parameter int GRACE_CYC  = 4,
  parameter int STORE_CYC  = 40,
  parameter int RECALL_CYC = 24,
  parameter int PUSH_CYC   = 3
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic vlow,
  input  logic vlow_q,
  input  logic line_in,
  input  logic dirty,
  input  logic as_en,
  input  logic recall_pend,
  input  logic sw_store,
  input  logic sw_recall,
  input  logic rd_req,
  input  logic wr_req,
  output logic rd_en,
  output logic wr_en,
  output logic cmd_ok,
  output logic line_pull_low,
  output logic line_push_high,
  output logic busy,
  output logic nv_commit,
  output logic manual_commit,
  output logic sram_clear,
  output logic sram_load
);

  localparam int MAX_A   = (GRACE_CYC > STORE_CYC) ? GRACE_CYC : STORE_CYC;
  localparam int MAX_B   = (RECALL_CYC > PUSH_CYC) ? RECALL_CYC : PUSH_CYC;
  localparam int MAX_ALL = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(MAX_ALL + 1);

  localparam logic [CNT_W-1:0] GRACE_LD  = CNT_W'(GRACE_CYC - 1);
  localparam logic [CNT_W-1:0] STORE_LD  = CNT_W'(STORE_CYC - 1);
  localparam logic [CNT_W-1:0] RECALL_LD = CNT_W'(RECALL_CYC - 1);
  localparam logic [CNT_W-1:0] PUSH_LD   = CNT_W'(PUSH_CYC - 1);

  nv_state_e        state_q, state_d;
  nv_src_e          src_q, src_d;
  logic             line_q;
  logic             wr_q;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic [CNT_W-1:0] tmr_cnt;
  logic             tmr_zero;
  logic             vlow_rise;
  logic             line_fall;
  logic             is_idle;
  logic             idle_open;

  assign vlow_rise = vlow && !vlow_q;
  assign line_fall = line_q && !line_in;
  assign is_idle   = (state_q == ST_IDLE);
  assign idle_open = is_idle && !vlow && line_in && !recall_pend;

  // Next-state decision; request priority in idle: supply loss, queued
  // recall, line request, software store, software recall.
  always_comb begin
    state_d = state_q;
    src_d   = src_q;
    unique case (state_q)
      ST_IDLE: begin
        if (vlow_rise) begin
          if (as_en && dirty) begin
            state_d = ST_GRACE;
            src_d   = SRC_AUTO;
          end
        end else if (vlow) begin
          state_d = ST_IDLE;
        end else if (recall_pend) begin
          state_d = ST_RECALL;
        end else if (line_fall) begin
          if (dirty) begin
            state_d = ST_GRACE;
            src_d   = SRC_PIN;
          end
        end else if (line_in && sw_store) begin
          state_d = ST_GRACE;
          src_d   = SRC_SW;
        end else if (line_in && sw_recall) begin
          state_d = ST_RECALL;
        end
      end
      ST_GRACE: begin
        if (tmr_zero) state_d = ST_STORE;
      end
      ST_STORE: begin
        if (tmr_zero) state_d = ST_PUSH;
      end
      ST_PUSH: begin
        if (tmr_zero) state_d = ST_IDLE;
      end
      ST_RECALL: begin
        if (vlow || tmr_zero) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (state_d)
      ST_GRACE:  tmr_val = GRACE_LD;
      ST_STORE:  tmr_val = STORE_LD;
      ST_PUSH:   tmr_val = PUSH_LD;
      ST_RECALL: tmr_val = RECALL_LD;
      default:   tmr_val = '0;
    endcase
  end

  assign tmr_load = (state_d != state_q);

  nvseq_timer #(
    .W(CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .load     (tmr_load),
    .load_val (tmr_val),
    .count    (tmr_cnt),
    .zero     (tmr_zero)
  );

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      src_q   <= SRC_SW;
      line_q  <= 1'b1;
      wr_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      src_q   <= src_d;
      line_q  <= line_in;
      wr_q    <= wr_en;
    end
  end

  assign rd_en  = rd_req && idle_open;
  assign wr_en  = wr_req && (idle_open || (state_q == ST_GRACE && wr_q));
  assign cmd_ok = idle_open;

  assign line_pull_low  = (state_q == ST_GRACE) || (state_q == ST_STORE) ||
                          (state_q == ST_RECALL);
  assign line_push_high = (state_q == ST_PUSH);
  assign busy           = !is_idle;

  assign nv_commit     = (state_q == ST_STORE) && tmr_zero;
  assign manual_commit = nv_commit && (src_q != SRC_AUTO);
  assign sram_clear    = (state_q == ST_RECALL) && (tmr_cnt == RECALL_LD) && !vlow;
  assign sram_load     = (state_q == ST_RECALL) && tmr_zero && !vlow;

  AST_STORE_AFTER_GRACE: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_STORE && $past(state_q) != ST_STORE) |-> $past(state_q) == ST_GRACE)
    else $error("store without grace"); // R7

  AST_PUSH_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_ni)
    nv_commit |=> (line_push_high && !line_pull_low)) else $error("no push after commit"); // R9

  AST_CLEAR_BEFORE_LOAD: assert property (@(posedge clk) disable iff (!rst_ni)
    sram_load |-> !sram_clear) else $error("clear and load together"); // R2

endmodule

// File: rtl/nvseq_ctrl.sv
module nvseq_ctrl #(
  parameter int GRACE_CYC  = 4,
  parameter int STORE_CYC  = 40,
  parameter int RECALL_CYC = 24,
  parameter int PUSH_CYC   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_low,
  input  logic line_in,
  input  logic sw_store,
  input  logic sw_recall,
  input  logic sw_as_enable,
  input  logic sw_as_disable,
  input  logic rd_req,
  input  logic wr_req,
  output logic rd_en,
  output logic wr_en,
  output logic line_pull_low,
  output logic line_push_high,
  output logic busy,
  output logic done,
  output logic nv_commit,
  output logic sram_clear,
  output logic sram_load,
  output logic dirty,
  output logic autostore_en
);

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_q;
  logic                   vlow_q;
  logic                   recall_pend;
  logic                   cmd_ok;
  logic                   manual_commit;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end

  assign rst_q = rst_sync_q[SYNC_STAGES-1];

  nvseq_fsm #(
    .GRACE_CYC  (GRACE_CYC),
    .STORE_CYC  (STORE_CYC),
    .RECALL_CYC (RECALL_CYC),
    .PUSH_CYC   (PUSH_CYC)
  ) u_fsm (
    .clk            (clk),
    .rst_ni         (rst_q),
    .vlow           (supply_low),
    .vlow_q         (vlow_q),
    .line_in        (line_in),
    .dirty          (dirty),
    .as_en          (autostore_en),
    .recall_pend    (recall_pend),
    .sw_store       (sw_store),
    .sw_recall      (sw_recall),
    .rd_req         (rd_req),
    .wr_req         (wr_req),
    .rd_en          (rd_en),
    .wr_en          (wr_en),
    .cmd_ok         (cmd_ok),
    .line_pull_low  (line_pull_low),
    .line_push_high (line_push_high),
    .busy           (busy),
    .nv_commit      (nv_commit),
    .manual_commit  (manual_commit),
    .sram_clear     (sram_clear),
    .sram_load      (sram_load)
  );

  nvseq_flags u_flags (
    .clk         (clk),
    .rst_ni      (rst_q),
    .vlow        (supply_low),
    .wr_acc      (wr_en),
    .cmd_ok      (cmd_ok),
    .as_set_cmd  (sw_as_enable),
    .as_clr_cmd  (sw_as_disable),
    .commit      (nv_commit),
    .manual      (manual_commit),
    .load        (sram_load),
    .dirty       (dirty),
    .as_en       (autostore_en),
    .recall_pend (recall_pend),
    .vlow_q      (vlow_q)
  );

  assign done = nv_commit || sram_load;

  AST_READ_GATED: assert property (@(posedge clk) disable iff (!rst_q)
    rd_en |-> (!supply_low && line_in && !busy)) else $error("read leaked"); // R8

  AST_WRITE_INFLIGHT: assert property (@(posedge clk) disable iff (!rst_q)
    (wr_en && busy) |-> $past(wr_en)) else $error("new write in grace"); // R7

  AST_COMMIT_CLEARS_DIRTY: assert property (@(posedge clk) disable iff (!rst_q)
    nv_commit |=> !dirty) else $error("dirty after commit"); // R10

  AST_LINE_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_q)
    !(line_pull_low && line_push_high)) else $error("line driven both ways"); // R9

endmodule

// File: tb/nvseq_ctrl_test.sv
module nvseq_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int G = 4;
  localparam int S = 40;
  localparam int R = 24;
  localparam int H = 3;

  localparam int EV_COMMIT = 0;
  localparam int EV_CLEAR  = 1;
  localparam int EV_LOAD   = 2;

  typedef struct {
    int kind;
    int cyc;
  } ev_t;

  logic clk;
  logic rst_n;
  logic supply_low, ext_pull;
  logic sw_store, sw_recall, sw_as_enable, sw_as_disable;
  logic rd_req, wr_req;
  logic rd_en, wr_en, line_pull_low, line_push_high, busy, done;
  logic nv_commit, sram_clear, sram_load, dirty, autostore_en;
  logic line_in;

  logic [2:0] wa;
  logic [7:0] wd;
  logic [7:0] sram_m [8];
  logic [7:0] nv_m   [8];

  ev_t exp_q[$];
  int  cyc;
  int  n_checks;
  int  n_fails;
  bit  finished;

  assign line_in = !(line_pull_low || ext_pull);

  nvseq_ctrl #(
    .GRACE_CYC  (G),
    .STORE_CYC  (S),
    .RECALL_CYC (R),
    .PUSH_CYC   (H)
  ) uut (
    .clk            (clk),
    .rst_n          (rst_n),
    .supply_low     (supply_low),
    .line_in        (line_in),
    .sw_store       (sw_store),
    .sw_recall      (sw_recall),
    .sw_as_enable   (sw_as_enable),
    .sw_as_disable  (sw_as_disable),
    .rd_req         (rd_req),
    .wr_req         (wr_req),
    .rd_en          (rd_en),
    .wr_en          (wr_en),
    .line_pull_low  (line_pull_low),
    .line_push_high (line_push_high),
    .busy           (busy),
    .done           (done),
    .nv_commit      (nv_commit),
    .sram_clear     (sram_clear),
    .sram_load      (sram_load),
    .dirty          (dirty),
    .autostore_en   (autostore_en)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) step();
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 1000 && busy; i++) step();
  endtask

  task automatic push_ev(input int kind, input int c);
    ev_t e;
    e.kind = kind;
    e.cyc  = c;
    exp_q.push_back(e);
  endtask

  // Monitor: compares every transfer strobe against the scoreboard and
  // keeps a data model of the array and its nonvolatile copy.
  task automatic pop_ev(input int kind, input string tag);
    ev_t e;
    if (exp_q.size() == 0) begin
      check(1'b0, {tag, " unexpected strobe"}, kind, -1);
    end else begin
      e = exp_q.pop_front();
      check(e.kind == kind && e.cyc == cyc, {tag, " strobe kind/cycle"},
            kind * 100000 + cyc, e.kind * 100000 + e.cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (sram_clear) begin
        pop_ev(EV_CLEAR, "R2");
        for (int i = 0; i < 8; i++) sram_m[i] = 8'h00;
      end
      if (nv_commit) begin
        pop_ev(EV_COMMIT, "R3");
        check(done, "R3 done with commit", int'(done), 1);
        for (int i = 0; i < 8; i++) nv_m[i] = sram_m[i];
      end
      if (sram_load) begin
        pop_ev(EV_LOAD, "R2");
        check(done, "R2 done with load", int'(done), 1);
        for (int i = 0; i < 8; i++) sram_m[i] = nv_m[i];
      end
      if (wr_en) sram_m[wa] = wd;
    end
  end

  task automatic do_write(input logic [2:0] a, input logic [7:0] d);
    wa = a;
    wd = d;
    wr_req = 1'b1;
    settle();
    check(wr_en, "R10 write accepted", int'(wr_en), 1);
    step();
    wr_req = 1'b0;
    settle();
    check(dirty, "R10 dirty after write", int'(dirty), 1);
    step();
  endtask

  task automatic sw_cmd_store();
    int k;
    k = cyc;
    sw_store = 1'b1;
    push_ev(EV_COMMIT, k + G + S);
    step();
    sw_store = 1'b0;
  endtask

  task automatic supply_restore();
    int k;
    k = cyc;
    supply_low = 1'b0;
    push_ev(EV_CLEAR, k + 1);
    push_ev(EV_LOAD, k + R);
    step();
    settle();
    check(line_pull_low, "R12 recall holds line", int'(line_pull_low), 1);
    step();
    wait_idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog all-R", 0, 1);
    finish_run();
  end

  initial begin
    int k;
    finished = 1'b0;
    n_checks = 0;
    n_fails  = 0;
    for (int i = 0; i < 8; i++) begin
      sram_m[i] = 8'h00;
      nv_m[i]   = 8'h00;
    end
    rst_n = 1'b0; supply_low = 1'b1; ext_pull = 1'b0;
    sw_store = 1'b0; sw_recall = 1'b0; sw_as_enable = 1'b0; sw_as_disable = 1'b0;
    rd_req = 1'b1; wr_req = 1'b1; wa = '0; wd = '0;

    // R1: reset state
    repeat (3) settle();
    check(!busy, "R1 busy in reset", int'(busy), 0);
    check(!line_pull_low && !line_push_high, "R1 line in reset",
          int'({line_pull_low, line_push_high}), 0);
    check(autostore_en && !dirty, "R1 flags in reset", int'({autostore_en, dirty}), 2);
    check(!rd_en && !wr_en, "R1 enables in reset", int'({rd_en, wr_en}), 0);
    step();
    rst_n = 1'b1;
    wr_req = 1'b0;
    repeat (4) step();
    settle();
    check(!rd_en, "R8 read blocked while supply low", int'(rd_en), 0);
    step();
    rd_req = 1'b0;

    // R2/R12: power-up recall
    k = cyc;
    supply_low = 1'b0;
    push_ev(EV_CLEAR, k + 1);
    push_ev(EV_LOAD, k + R);
    step();
    rd_req = 1'b1;
    settle();
    check(line_pull_low && busy, "R2 line low during recall", int'(line_pull_low), 1);
    check(!rd_en, "R8 read blocked in recall", int'(rd_en), 0);
    step();
    rd_req = 1'b0;
    wait_idle();
    settle();
    check(!dirty, "R10 clean after recall", int'(dirty), 0);
    step();

    // R3/R9/R10: software store with dirty data
    do_write(3'd1, 8'hA1);
    k = cyc;
    sw_cmd_store();
    wait_until(k + G + S + 1);
    settle();
    check(line_push_high && !line_pull_low, "R9 push high after commit",
          int'({line_push_high, line_pull_low}), 2);
    check(!dirty, "R10 dirty cleared by commit", int'(dirty), 0);
    check(nv_m[1] == 8'hA1, "R3 data committed", int'(nv_m[1]), 'hA1);
    wait_until(k + G + S + H);
    settle();
    check(line_push_high, "R9 push high last cycle", int'(line_push_high), 1);
    step();
    settle();
    check(!line_push_high && !busy, "R9 released after push",
          int'({line_push_high, busy}), 0);
    step();

    // R3: software store with clean data still runs
    sw_cmd_store();
    wait_idle();
    settle();
    check(exp_q.size() == 0, "R3 clean store ran", exp_q.size(), 0);
    step();

    // R5: line pulled low with clean data
    ext_pull = 1'b1;
    for (int i = 0; i < 5; i++) begin
      step();
      settle();
      check(!line_pull_low && !busy, "R5 no drive when clean",
            int'({line_pull_low, busy}), 0);
    end
    step();
    wr_req = 1'b1; rd_req = 1'b1; wa = 3'd2; wd = 8'h22;
    settle();
    check(!wr_en && !rd_en, "R5 access blocked while line low", int'({wr_en, rd_en}), 0);
    step();
    ext_pull = 1'b0;
    settle();
    check(wr_en && rd_en, "R5 access resumes on release", int'({wr_en, rd_en}), 3);
    step();
    wr_req = 1'b0; rd_req = 1'b0;
    step();

    // R4: line pulled low with dirty data
    k = cyc;
    ext_pull = 1'b1;
    push_ev(EV_COMMIT, k + G + S);
    step();
    settle();
    check(line_pull_low && busy, "R4 line held low", int'(line_pull_low), 1);
    wait_until(k + G + S + H + 2);
    wr_req = 1'b1; wa = 3'd6; wd = 8'h66;
    settle();
    check(!busy && !line_pull_low, "R4 store finished", int'({busy, line_pull_low}), 0);
    check(!wr_en, "R5 locked while line held", int'(wr_en), 0);
    check(nv_m[2] == 8'h22, "R4 data committed", int'(nv_m[2]), 'h22);
    step();
    wr_req = 1'b0;
    ext_pull = 1'b0;
    step();

    // R7: grace window
    k = cyc;
    wa = 3'd3; wd = 8'h33; wr_req = 1'b1; sw_store = 1'b1;
    push_ev(EV_COMMIT, k + G + S);
    step();
    sw_store = 1'b0;
    settle();
    check(wr_en && line_pull_low, "R7 in-flight write continues", int'(wr_en), 1);
    step();
    wr_req = 1'b0;
    step();
    wr_req = 1'b1; wa = 3'd7; wd = 8'h77;
    settle();
    check(!wr_en, "R7 new write refused", int'(wr_en), 0);
    step();
    wr_req = 1'b0;
    wait_idle();
    settle();
    check(nv_m[3] == 8'h33 && nv_m[7] == 8'h00, "R7 only in-flight data stored",
          int'(nv_m[3]), 'h33);
    step();

    // R11/R6: disable, no automatic store, recall reloads saved enable
    sw_as_disable = 1'b1;
    step();
    sw_as_disable = 1'b0;
    settle();
    check(!autostore_en, "R11 disable command", int'(autostore_en), 0);
    step();
    do_write(3'd4, 8'h44);
    supply_low = 1'b1;
    for (int i = 0; i < 6; i++) step();
    settle();
    check(!busy && dirty, "R6 no store when disabled", int'({busy, dirty}), 1);
    step();
    supply_restore();
    settle();
    check(autostore_en, "R11 reload saved enable", int'(autostore_en), 1);
    check(sram_m[4] == 8'h00 && sram_m[3] == 8'h33, "R2 array restored",
          int'(sram_m[4]), 0);
    check(!dirty, "R10 dirty cleared by recall", int'(dirty), 0);
    step();

    // R11: manual store persists the disabled flag
    sw_as_disable = 1'b1;
    step();
    sw_as_disable = 1'b0;
    sw_cmd_store();
    wait_idle();
    do_write(3'd5, 8'h55);
    supply_low = 1'b1;
    for (int i = 0; i < 6; i++) step();
    settle();
    check(!busy, "R6 no store, flag off", int'(busy), 0);
    step();
    supply_restore();
    settle();
    check(!autostore_en, "R11 disabled flag persisted", int'(autostore_en), 0);
    step();

    // R6/R8/R12: enabled, dirty, supply loss triggers store
    sw_as_enable = 1'b1;
    step();
    sw_as_enable = 1'b0;
    settle();
    check(autostore_en, "R11 enable command", int'(autostore_en), 1);
    step();
    do_write(3'd5, 8'h5A);
    k = cyc;
    supply_low = 1'b1;
    push_ev(EV_COMMIT, k + G + S);
    step();
    wr_req = 1'b1;
    settle();
    check(line_pull_low, "R6 automatic store started", int'(line_pull_low), 1);
    check(!wr_en, "R8 write blocked in automatic store", int'(wr_en), 0);
    step();
    wr_req = 1'b0;
    wait_idle();
    rd_req = 1'b1;
    settle();
    check(!rd_en && !busy, "R8 read blocked while supply low", int'(rd_en), 0);
    check(nv_m[5] == 8'h5A, "R6 data saved on supply loss", int'(nv_m[5]), 'h5A);
    step();
    rd_req = 1'b0;
    supply_restore();
    settle();
    check(!autostore_en, "R11 automatic store did not save flag", int'(autostore_en), 0);
    step();

    // R6: enabled but clean, no store
    sw_as_enable = 1'b1;
    step();
    sw_as_enable = 1'b0;
    supply_low = 1'b1;
    for (int i = 0; i < 6; i++) step();
    settle();
    check(!busy && !line_pull_low, "R6 no store when clean", int'(busy), 0);
    step();
    supply_restore();

    // R2: software recall discards unsaved data
    do_write(3'd6, 8'h99);
    k = cyc;
    sw_recall = 1'b1;
    push_ev(EV_CLEAR, k + 1);
    push_ev(EV_LOAD, k + R);
    step();
    sw_recall = 1'b0;
    wait_idle();
    settle();
    check(sram_m[6] == 8'h00 && sram_m[5] == 8'h5A, "R2 software recall result",
          int'(sram_m[6]), 0);
    check(exp_q.size() == 0, "R2 all strobes seen", exp_q.size(), 0);
    step();

    finish_run();
  end

endmodule